// File: doc/BRIEF.md
# Split-Register Wide Counter Reader

This block keeps a 56-bit timestamp that counts up by one in every clock cycle where the tick enable is high, and rolls over to zero after its all-ones value. The count is visible through a single-cycle combinational read port as two 32-bit words. One offset returns bits 31:0. A second offset returns bits 55:32, zero-extended. The two words are never latched as a pair, so a reader that fetches them one after the other can pair a stale upper word with a fresh lower word when a carry crosses the word boundary.

A built-in reader engine avoids that tear. On a request it reads the upper word and then the lower word. It then reads the upper word again. If the two upper reads differ, it keeps the newer upper word and reads the lower word and the upper word once more. The engine stops when two upper reads in a row match. It then presents the merged 56-bit value with a one-cycle valid strobe. The engine uses the same word view that the external port uses, with its own address.

Top module: `wide_stamp_reader`

## Requirements
- R1: The count loads INIT_VALUE while rstN is low. It goes up by exactly one on each rising clock edge where tickEn is high and holds otherwise. After 2^56-1 it returns to 0.
- R2: regRdata shows the count in the same cycle. Offset 0x0 returns count bits 31:0. Offset 0x4 returns count bits 55:32 in bits 23:0, with bits 31:24 at zero. Any other offset returns zero.
- R3: Reading either word captures nothing. Both words always reflect the live count, so a value assembled by hand from two reads taken across a carry can be torn.
- R4: If readReq is high on a rising edge while the engine is idle, the engine takes the upper word on that edge, takes the lower word on the next edge, and compares the upper word on the edge after that. With a match, readValid is high during the third cycle after the request edge.
- R5: If the second upper read differs from the saved one, the engine saves the new upper word and repeats the lower and upper reads. Each retry adds two cycles before readValid.
- R6: readValue on the valid cycle equals {matching upper word, last lower word}. This equals the count value seen at the last lower-word read, so it is never a mix of two different count values.
- R7: readValid is high for one cycle per completed read. readValue changes only in a cycle where readValid is high and holds its value between strobes.
- R8: A readReq that arrives while the engine is busy is ignored. A readReq in the cycle where readValid is high is accepted as a new read.
- R9: After reset, readValid and readValue are zero and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Count advance enable, one step per cycle |
| regAddr | input | ADDR_W (4) | Byte offset for the external word read |
| regRdata | output | WORD_W (32) | Word selected by regAddr, combinational |
| readReq | input | 1 | Request a coherent read of the full count |
| readValid | output | 1 | One-cycle strobe that marks a new readValue |
| readValue | output | CNT_W (56) | Coherent count from the latest completed read |

## Verification
A wrong upper-word snapshot or a missed retry shows up at the ports as a valid strobe carrying a value that jumps 2^32 away from the running count. It also shows up as a strobe that arrives three cycles after the request when five were due. Both are visible on the first strobe after the carry. The directed cases therefore place a single tick on the request edge, on the lower-read edge, or on every edge across the 56-bit rollover, so that the carry falls between the two upper reads. A fault in the counter or in the word view shows up on regRdata in the cycle after the bad step, because the behavioural model is compared on every clock.

// File: rtl/stamp_pkg.sv
package stamp_pkg;

  // Reader engine phases
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } engState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capHi;    // save upper word as snapshot
    logic capLo;    // save lower word
    logic publish;  // merge snapshot and lower word into result
  } engStrobe_t;

endpackage

// File: rtl/stamp_regview.sv
module stamp_regview #(
  parameter int CNT_W     = 56,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int LO_OFFSET = 0,
  parameter int HI_OFFSET = 4
) (
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] data
);
  localparam int HI_W = CNT_W - WORD_W;

  logic [HI_W-1:0] hiPart;
  assign hiPart = count[CNT_W-1:WORD_W];

  always_comb begin
    if (addr == ADDR_W'(LO_OFFSET))
      data = count[WORD_W-1:0];
    else if (addr == ADDR_W'(HI_OFFSET))
      data = WORD_W'(hiPart);
    else
      data = '0;
  end
endmodule

// File: rtl/stamp_datapath.sv
module stamp_datapath
  import stamp_pkg::*;
#(
  parameter int              CNT_W      = 56,
  parameter int              WORD_W     = 32,
  parameter int              ADDR_W     = 4,
  parameter int              LO_OFFSET  = 0,
  parameter int              HI_OFFSET  = 4,
  parameter logic [CNT_W-1:0] INIT_VALUE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic [ADDR_W-1:0] engAddr,
  input  engStrobe_t        strobe,
  output logic [WORD_W-1:0] extData,
  output logic              hiMatch,
  output logic [CNT_W-1:0]  countNow,
  output logic [CNT_W-1:0]  resultValue,
  output logic              resultValid
);
  localparam int HI_W    = CNT_W - WORD_W;
  localparam int N_PORTS = 2;

  logic [CNT_W-1:0]  count;
  logic [HI_W-1:0]   snapHi;
  logic [WORD_W-1:0] lowWord;
  logic [ADDR_W-1:0] portAddr [N_PORTS];
  logic [WORD_W-1:0] portData [N_PORTS];
  logic [WORD_W-1:0] engData;

  // Free-running count, natural wrap at 2^CNT_W
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       count <= INIT_VALUE;
    else if (tickEn) count <= count + 1'b1;
  end

  // Port 0 serves the outside, port 1 serves the reader engine
  assign portAddr[0] = extAddr;
  assign portAddr[1] = engAddr;

  for (genvar gp = 0; gp < N_PORTS; gp++) begin : g_view
    stamp_regview #(
      .CNT_W(CNT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
      .LO_OFFSET(LO_OFFSET), .HI_OFFSET(HI_OFFSET)
    ) u_view (
      .count(count),
      .addr (portAddr[gp]),
      .data (portData[gp])
    );
  end

  assign extData = portData[0];
  assign engData = portData[1];

  assign hiMatch = (engData[HI_W-1:0] == snapHi);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapHi      <= '0;
      lowWord     <= '0;
      resultValue <= '0;
      resultValid <= 1'b0;
    end else begin
      if (strobe.capHi)   snapHi      <= engData[HI_W-1:0];
      if (strobe.capLo)   lowWord     <= engData;
      if (strobe.publish) resultValue <= {snapHi, lowWord};
      resultValid <= strobe.publish;
    end
  end

  assign countNow = count;
endmodule

// File: rtl/stamp_ctrl.sv
module stamp_ctrl
  import stamp_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int LO_OFFSET = 0,
  parameter int HI_OFFSET = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readReq,
  input  logic              hiMatch,
  output logic [ADDR_W-1:0] engAddr,
  output engStrobe_t        strobe,
  output logic              busy
);
  engState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    engAddr   = ADDR_W'(HI_OFFSET);
    unique case (state)
      ST_IDLE: begin
        if (readReq) begin
          strobe.capHi = 1'b1;
          nextState    = ST_LOW;
        end
      end
      ST_LOW: begin
        engAddr      = ADDR_W'(LO_OFFSET);
        strobe.capLo = 1'b1;
        nextState    = ST_HIGH;
      end
      ST_HIGH: begin
        if (hiMatch) begin
          strobe.publish = 1'b1;
          nextState      = ST_IDLE;
        end else begin
          strobe.capHi = 1'b1;
          nextState    = ST_LOW;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/wide_stamp_reader.sv
module wide_stamp_reader
  import stamp_pkg::*;
#(
  parameter int               CNT_W      = 56,
  parameter int               WORD_W     = 32,
  parameter int               ADDR_W     = 4,
  parameter int               LO_OFFSET  = 0,
  parameter int               HI_OFFSET  = 4,
  parameter logic [CNT_W-1:0] INIT_VALUE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [WORD_W-1:0] regRdata,
  input  logic              readReq,
  output logic              readValid,
  output logic [CNT_W-1:0]  readValue
);
  engStrobe_t        strobe;
  logic [ADDR_W-1:0] engAddr;
  logic              hiMatch;
  logic              engBusy;
  logic [CNT_W-1:0]  countNow;

  stamp_ctrl #(
    .ADDR_W(ADDR_W), .LO_OFFSET(LO_OFFSET), .HI_OFFSET(HI_OFFSET)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .readReq(readReq),
    .hiMatch(hiMatch),
    .engAddr(engAddr),
    .strobe (strobe),
    .busy   (engBusy)
  );

  stamp_datapath #(
    .CNT_W(CNT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .LO_OFFSET(LO_OFFSET), .HI_OFFSET(HI_OFFSET), .INIT_VALUE(INIT_VALUE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .extAddr    (regAddr),
    .engAddr    (engAddr),
    .strobe     (strobe),
    .extData    (regRdata),
    .hiMatch    (hiMatch),
    .countNow   (countNow),
    .resultValue(readValue),
    .resultValid(readValid)
  );
endmodule

// File: rtl/stamp_reader_checks.sv
module stamp_reader_checks #(
  parameter int CNT_W     = 56,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int LO_OFFSET = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [WORD_W-1:0] regRdata,
  input logic              readReq,
  input logic              readValid,
  input logic [CNT_W-1:0]  readValue,
  input logic [CNT_W-1:0]  countNow,
  input logic              engBusy
);
  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(countNow));

  p_count_moves_r1: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> countNow != $past(countNow));

  p_low_view_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(LO_OFFSET)) |-> regRdata == countNow[WORD_W-1:0]);

  p_req_starts_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!engBusy && readReq) |=> engBusy);

  p_valid_after_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    readValid |-> $past(engBusy));

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    readValid |=> !readValid);

  p_value_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    !readValid |-> $stable(readValue));
endmodule

bind wide_stamp_reader stamp_reader_checks #(
  .CNT_W(CNT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .LO_OFFSET(LO_OFFSET)
) u_checks (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .regAddr  (regAddr),
  .regRdata (regRdata),
  .readReq  (readReq),
  .readValid(readValid),
  .readValue(readValue),
  .countNow (countNow),
  .engBusy  (engBusy)
);

// File: tb/wide_stamp_reader_bench.sv
`timescale 1ns/1ps
module wide_stamp_reader_bench;
  localparam logic [55:0] INIT = 56'hFF_FFFF_FFFF_FFF0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [3:0]  regAddr = 4'h0;
  logic [31:0] regRdata;
  logic        readReq = 1'b0;
  logic        readValid;
  logic [55:0] readValue;

  int  total = 0;
  int  bad = 0;
  bit  armed = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  wide_stamp_reader #(.INIT_VALUE(INIT)) u_wide_stamp_reader (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regAddr(regAddr),
    .regRdata(regRdata), .readReq(readReq), .readValid(readValid),
    .readValue(readValue)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: live count plus the retry read algorithm
  logic [55:0] mCount;
  int          mPhase;
  logic [23:0] mSnap;
  logic [31:0] mLow;
  logic        mValid;
  logic [55:0] mValue;

  function automatic logic [31:0] viewOf(input logic [3:0] a, input logic [55:0] c);
    if (a == 4'h0) return c[31:0];
    if (a == 4'h4) return {8'h00, c[55:32]};
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = INIT; mPhase = 0; mValid = 0; mValue = '0; mSnap = '0; mLow = '0;
    end else begin
      mValid = 0;
      case (mPhase)
        0: if (readReq) begin mSnap = mCount[55:32]; mPhase = 1; end
        1: begin mLow = mCount[31:0]; mPhase = 2; end
        default: begin
          if (mCount[55:32] == mSnap) begin
            mValid = 1; mValue = {mSnap, mLow}; mPhase = 0;
          end else begin
            mSnap = mCount[55:32]; mPhase = 1;
          end
        end
      endcase
      if (tickEn) mCount = mCount + 1'b1;
    end
  end

  // Per-clock comparison after the edge has settled
  always @(posedge clk) begin
    #2;
    if (armed && rstN) begin
      check(regRdata == viewOf(regAddr, mCount), "R3 live word view vs model",
            64'(regRdata), 64'(viewOf(regAddr, mCount)));
      check(readValid == mValid, "R5 valid timing vs model",
            64'(readValid), 64'(mValid));
      if (mValid)
        check(readValue == mValue, "R6 coherent value vs model",
              64'(readValue), 64'(mValue));
    end
  end

  task automatic doReset();
    @(negedge clk); rstN = 0; readReq = 0; tickEn = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    armed = 1;
  endtask

  task automatic advance(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tickEn = 1; end
    @(negedge clk); tickEn = 0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  task automatic runRead(input logic [9:0] reqPat, input logic [9:0] tickPat,
                         output int lat, output logic [55:0] val, output int nValid);
    lat = -1; val = '0; nValid = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (readValid) begin
        nValid++;
        if (lat < 0) begin lat = k; val = readValue; end
      end
      readReq = reqPat[k];
      tickEn  = tickPat[k];
    end
    @(negedge clk);
    if (readValid) nValid++;
    readReq = 0; tickEn = 0;
    regAddr = 4'h0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R4 watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat, nv;
    logic [55:0] v;
    logic [31:0] d;

    doReset();
    // R9 reset state
    check(readValid == 0, "R9 readValid after reset", 64'(readValid), 0);
    check(readValue == 0, "R9 readValue after reset", 64'(readValue), 0);
    check(regRdata == INIT[31:0], "R1 reset loads INIT", 64'(regRdata), 64'(INIT[31:0]));

    // R2 word view at both offsets and an unused one
    peek(4'h0, d); check(d == 32'hFFFF_FFF0, "R2 low word offset 0x0", 64'(d), 64'hFFFF_FFF0);
    peek(4'h4, d); check(d == 32'h00FF_FFFF, "R2 high word offset 0x4", 64'(d), 64'h00FF_FFFF);
    peek(4'h8, d); check(d == 32'h0, "R2 unused offset reads zero", 64'(d), 0);

    // R1 hold without tick
    repeat (4) @(negedge clk);
    peek(4'h0, d); check(d == 32'hFFFF_FFF0, "R1 holds without tick", 64'(d), 64'hFFFF_FFF0);

    // R4 quiet read: three cycles, exact value
    runRead(10'b00_0000_0001, 10'b0, lat, v, nv);
    check(lat == 3, "R4 latency without carry", 64'(lat), 3);
    check(v == INIT, "R6 value without ticks", v, INIT);

    // R6 ticking on every cycle: value is the count at the low read
    doReset();
    runRead(10'b00_0000_0001, 10'b11_1111_1111, lat, v, nv);
    check(lat == 3, "R4 latency while ticking", 64'(lat), 3);
    check(v == INIT + 1, "R6 value while ticking", v, INIT + 1);

    // R8 requests while busy are ignored
    doReset();
    runRead(10'b00_0000_0111, 10'b0, lat, v, nv);
    check(nv == 1, "R8 busy requests ignored", 64'(nv), 1);
    check(lat == 3, "R8 first read unaffected", 64'(lat), 3);
    // R8 request in the valid cycle is taken
    runRead(10'b00_0000_1001, 10'b0, lat, v, nv);
    check(nv == 2, "R8 request on valid cycle accepted", 64'(nv), 2);

    // R5 carry between first high read and low read
    doReset();
    advance(15);
    runRead(10'b00_0000_0001, 10'b00_0000_0001, lat, v, nv);
    check(lat == 5, "R5 retry latency, tick on request edge", 64'(lat), 5);
    check(v == 56'h0, "R6 untorn across rollover A", v, 0);

    // R5 carry between low read and second high read
    doReset();
    advance(15);
    runRead(10'b00_0000_0001, 10'b00_0000_0010, lat, v, nv);
    check(lat == 5, "R5 retry latency, tick on low edge", 64'(lat), 5);
    check(v == 56'h0, "R6 untorn across rollover B", v, 0);

    // R5 carry with ticks on every edge through the retry
    doReset();
    advance(14);
    runRead(10'b00_0000_0001, 10'b11_1111_1111, lat, v, nv);
    check(lat == 5, "R5 retry latency with steady ticks", 64'(lat), 5);
    check(v == 56'h1, "R6 value after retry with ticks", v, 1);
    check(v != 56'hFF_FFFF_0000_0001, "R3 torn pairing not returned", v, 1);

    // R1 wrap to zero
    doReset();
    advance(16);
    peek(4'h0, d); check(d == 32'h0, "R1 low word after wrap", 64'(d), 0);
    peek(4'h4, d); check(d == 32'h0, "R1 high word after wrap", 64'(d), 0);

    // R7 value held after the strobe
    runRead(10'b00_0000_0001, 10'b0, lat, v, nv);
    repeat (3) @(negedge clk);
    check(readValue == 56'h0 && !readValid, "R7 value held between strobes", readValue, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule